// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Idle Parking

This block arbitrates one slave port of a multi-master, AHB-style crossbar. Each master presents a request for this port, a lock flag and its address-phase controls. The block keeps one registered owner. It hands ownership from master to master in rotating order, and only in a cycle where the slave reports ready. It steers the owner's controls onto the slave bus.

When nobody requests the port, the port parks according to a two-bit mode input and a park index input. A master that is holding a locked sequence keeps the port through idle periods and against competing requests. This lets it leave the slave and come back without any other master getting in between.

Because the owner is registered, the master that already holds the port starts its transfer with no delay. Any other master is seen on the slave bus one clock after the ready cycle in which it won.

Top module: `xbp_slave_arb`

## Requirements
- R1: In a ready cycle without lock hold and with at least one request, the next owner is the first requesting master found by searching cyclically from the rotation pointer. The pointer is 0 after reset and becomes the winner's index plus one (wrapping at NUM_M) after each such grant.
- R2: While s_ready is low, owner_vld and owner_idx keep their values.
- R3: While the owner is valid, s_addr and s_write follow the owner. If the owner is not requesting this port in that cycle, s_trans, s_burst, s_lock and s_master are 0 in that same cycle.
- R4: Park mode 2'b00 (fixed): in a ready cycle with no requests and no lock hold, the next owner is park_id, and it is valid. A park_id of NUM_M or more selects master 0.
- R5: Park mode 2'b01 (last): in a ready cycle with no requests and no lock hold, owner_vld and owner_idx are kept.
- R6: Park mode 2'b10 or 2'b11 (low power): in a ready cycle with no requests and no lock hold, owner_vld becomes 0. While owner_vld is 0, every slave-bus output is 0.
- R7: A requesting owner's s_trans, s_burst, s_lock and s_master (equal to its index) appear in the current cycle. Any other requester gains the port only at the next clock edge after a ready cycle.
- R8: Lock hold applies in a ready cycle when the owner is valid, its lock is high, and it is either requesting or was already under lock hold at the previous ready cycle. Under lock hold the owner is kept, whatever the mode and the other requests.
- R9: After reset, owner_vld is 0, owner_idx is 0, and no lock hold is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| park_mode | input | 2 | 00 fixed, 01 last owner, 1x low power |
| park_id | input | IW | Master index used by fixed parking |
| s_ready | input | 1 | Slave ready; marks a transfer boundary |
| m_req | input | NUM_M | Per-master request for this port |
| m_lock | input | NUM_M | Per-master lock flag |
| m_trans | input | 2*NUM_M | Per-master transfer type, master i at bits [2i+1:2i] |
| m_burst | input | 3*NUM_M | Per-master burst type, master i at bits [3i+2:3i] |
| m_addr | input | ADDR_W*NUM_M | Per-master address, master i in slice i |
| m_write | input | NUM_M | Per-master write flag |
| s_trans | output | 2 | Steered transfer type |
| s_burst | output | 3 | Steered burst type |
| s_addr | output | ADDR_W | Steered address |
| s_write | output | 1 | Steered write flag |
| s_lock | output | 1 | Steered lock |
| s_master | output | MID_W | Owner index as master ID |
| owner_vld | output | 1 | Port has an owner |
| owner_idx | output | IW | Current owner index |

## Verification
Two functions can fall in the same cycle. A master can keep its lock high, stop requesting this port and go elsewhere, while another master requests the port and the mode asks for low-power or fixed parking. The bench provokes this with sweeps of every mode and park index, driving sparse random lock bits together with dense requests and gaps in ready. Each cycle it judges the result against a bench model: lock hold must win over both the round-robin grant and parking, and the forced-zero steering of R3 must still apply to the held owner.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

  typedef enum logic [1:0] {
    PARK_FIXED  = 2'b00,
    PARK_LAST   = 2'b01,
    PARK_LOWPWR = 2'b10
  } park_mode_e;

endpackage

// File: rtl/xbp_rr_pick.sv
module xbp_rr_pick #(
  parameter int NUM_M = 4,
  parameter int IW    = 2
) (
  input  logic [NUM_M-1:0] req,
  input  logic [IW-1:0]    start,
  output logic             found,
  output logic [IW-1:0]    pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_M; k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= NUM_M) idx = idx - NUM_M;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/xbp_owner_ctl.sv
module xbp_owner_ctl
  import xbp_pkg::*;
#(
  parameter int NUM_M = 4,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_ready,
  input  logic [NUM_M-1:0] m_req,
  input  logic [NUM_M-1:0] m_lock,
  input  logic [1:0]       park_mode,
  input  logic [IW-1:0]    park_id,
  output logic [IW-1:0]    owner,
  output logic             owner_vld
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_M - 1);

  logic [IW-1:0] own_q, own_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          vld_q, vld_d;
  logic          hold_q, hold_d;
  logic          stick;
  logic          win_found;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] park_sel;
  logic          no_req;

  xbp_rr_pick #(.NUM_M(NUM_M), .IW(IW)) u_pick (
    .req   (m_req),
    .start (ptr_q),
    .found (win_found),
    .pick  (win_idx)
  );

  assign stick    = vld_q & m_lock[own_q] & (m_req[own_q] | hold_q);
  assign park_sel = (32'(park_id) < NUM_M) ? park_id : '0;
  assign no_req   = (m_req == '0);

  always_comb begin
    own_d  = own_q;
    vld_d  = vld_q;
    ptr_d  = ptr_q;
    hold_d = hold_q;
    if (s_ready) begin
      hold_d = stick;
      if (stick) begin
        own_d = own_q;
      end else if (win_found) begin
        own_d = win_idx;
        vld_d = 1'b1;
        ptr_d = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
      end else begin
        case (park_mode)
          PARK_FIXED: begin
            own_d = park_sel;
            vld_d = 1'b1;
          end
          PARK_LAST: begin
            vld_d = vld_q;
          end
          default: begin
            vld_d = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      ptr_q  <= '0;
      hold_q <= 1'b0;
    end else if (s_ready) begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
    end
  end

  assign owner     = own_q;
  assign owner_vld = vld_q;

  a_r2_hold_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> $stable(own_q) && $stable(vld_q));

  a_r8_lock_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && stick) |=> vld_q && (own_q == $past(own_q)));

  a_r1_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !stick && !no_req) |=> vld_q && (|($past(m_req) & (NUM_M'(1) << own_q))));

  a_r4_fixed_park: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !stick && no_req && park_mode == PARK_FIXED)
      |=> vld_q && (own_q == $past(park_sel)));

  a_r5_last_park: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !stick && no_req && park_mode == PARK_LAST)
      |=> (vld_q == $past(vld_q)) && (own_q == $past(own_q)));

  a_r6_lowpower_release: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !stick && no_req && park_mode[1]) |=> !vld_q);

endmodule

// File: rtl/xbp_steer.sv
module xbp_steer #(
  parameter int NUM_M  = 4,
  parameter int IW     = 2,
  parameter int ADDR_W = 32,
  parameter int MID_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IW-1:0]           owner,
  input  logic                    owner_vld,
  input  logic [NUM_M-1:0]        m_req,
  input  logic [NUM_M-1:0]        m_lock,
  input  logic [2*NUM_M-1:0]      m_trans,
  input  logic [3*NUM_M-1:0]      m_burst,
  input  logic [ADDR_W*NUM_M-1:0] m_addr,
  input  logic [NUM_M-1:0]        m_write,
  output logic [1:0]              s_trans,
  output logic [2:0]              s_burst,
  output logic [ADDR_W-1:0]       s_addr,
  output logic                    s_write,
  output logic                    s_lock,
  output logic [MID_W-1:0]        s_master
);

  logic [1:0]        trans_a [NUM_M];
  logic [2:0]        burst_a [NUM_M];
  logic [ADDR_W-1:0] addr_a  [NUM_M];

  for (genvar g = 0; g < NUM_M; g++) begin : g_slice
    assign trans_a[g] = m_trans[g*2 +: 2];
    assign burst_a[g] = m_burst[g*3 +: 3];
    assign addr_a[g]  = m_addr[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    s_trans  = '0;
    s_burst  = '0;
    s_addr   = '0;
    s_write  = 1'b0;
    s_lock   = 1'b0;
    s_master = '0;
    if (owner_vld) begin
      s_addr  = addr_a[owner];
      s_write = m_write[owner];
      if (m_req[owner]) begin
        s_trans  = trans_a[owner];
        s_burst  = burst_a[owner];
        s_lock   = m_lock[owner];
        s_master = MID_W'(owner);
      end
    end
  end

  a_r6_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_vld |-> (s_trans == '0) && (s_addr == '0) && !s_lock && (s_master == '0));

  a_r3_forced_when_away: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && !m_req[owner]) |-> (s_trans == '0) && (s_burst == '0) && !s_lock);

endmodule

// File: rtl/xbp_slave_arb.sv
module xbp_slave_arb #(
  parameter int NUM_M  = 4,
  parameter int ADDR_W = 32,
  parameter int MID_W  = 4,
  localparam int IW    = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              park_mode,
  input  logic [IW-1:0]           park_id,
  input  logic                    s_ready,
  input  logic [NUM_M-1:0]        m_req,
  input  logic [NUM_M-1:0]        m_lock,
  input  logic [2*NUM_M-1:0]      m_trans,
  input  logic [3*NUM_M-1:0]      m_burst,
  input  logic [ADDR_W*NUM_M-1:0] m_addr,
  input  logic [NUM_M-1:0]        m_write,
  output logic [1:0]              s_trans,
  output logic [2:0]              s_burst,
  output logic [ADDR_W-1:0]       s_addr,
  output logic                    s_write,
  output logic                    s_lock,
  output logic [MID_W-1:0]        s_master,
  output logic                    owner_vld,
  output logic [IW-1:0]           owner_idx
);

  logic [IW-1:0] own;
  logic          own_vld;

  xbp_owner_ctl #(.NUM_M(NUM_M), .IW(IW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .m_req     (m_req),
    .m_lock    (m_lock),
    .park_mode (park_mode),
    .park_id   (park_id),
    .owner     (own),
    .owner_vld (own_vld)
  );

  xbp_steer #(.NUM_M(NUM_M), .IW(IW), .ADDR_W(ADDR_W), .MID_W(MID_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (own),
    .owner_vld (own_vld),
    .m_req     (m_req),
    .m_lock    (m_lock),
    .m_trans   (m_trans),
    .m_burst   (m_burst),
    .m_addr    (m_addr),
    .m_write   (m_write),
    .s_trans   (s_trans),
    .s_burst   (s_burst),
    .s_addr    (s_addr),
    .s_write   (s_write),
    .s_lock    (s_lock),
    .s_master  (s_master)
  );

  assign owner_vld = own_vld;
  assign owner_idx = own;

endmodule

// File: tb/sim_xbp_slave_arb.sv
module sim_xbp_slave_arb;

  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    park_mode;
  logic [1:0]    park_id;
  logic          s_ready;
  logic [N-1:0]  m_req, m_lock, m_write;
  logic [2*N-1:0]  m_trans;
  logic [3*N-1:0]  m_burst;
  logic [AW*N-1:0] m_addr;
  logic [1:0]    s_trans;
  logic [2:0]    s_burst;
  logic [AW-1:0] s_addr;
  logic          s_write, s_lock, owner_vld;
  logic [3:0]    s_master;
  logic [1:0]    owner_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [1:0] mo, mptr;
  logic       mv, mhold;
  string      why;

  always #2 clk = ~clk;

  xbp_slave_arb #(.NUM_M(N), .ADDR_W(AW), .MID_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .park_mode(park_mode), .park_id(park_id),
    .s_ready(s_ready), .m_req(m_req), .m_lock(m_lock), .m_trans(m_trans),
    .m_burst(m_burst), .m_addr(m_addr), .m_write(m_write),
    .s_trans(s_trans), .s_burst(s_burst), .s_addr(s_addr), .s_write(s_write),
    .s_lock(s_lock), .s_master(s_master), .owner_vld(owner_vld), .owner_idx(owner_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] lk, input logic rdy);
    logic stick;
    m_req = rq; m_lock = lk; s_ready = rdy;
    for (int i = 0; i < N; i++) begin
      m_trans[i*2 +: 2]  = {1'b1, cyc[i]};
      m_burst[i*3 +: 3]  = 3'(i + cyc);
      m_addr[i*AW +: AW] = {2'(i), 6'(cyc)};
      m_write[i]         = cyc[i];
    end
    #1;
    chk({why, " owner_vld"}, int'(owner_vld), int'(mv));
    if (mv) chk({why, " owner_idx"}, int'(owner_idx), int'(mo));
    if (!mv) begin
      chk("R6 idle bus", int'({s_trans, s_burst, s_addr, s_write, s_lock, s_master}), 0);
    end else begin
      chk("R3 addr follows owner", int'({s_addr, s_write}), int'({m_addr[mo*AW +: AW], m_write[mo]}));
      if (rq[mo])
        chk("R7 owner passes now", int'({s_trans, s_burst, s_lock, s_master}),
            int'({m_trans[mo*2 +: 2], m_burst[mo*3 +: 3], lk[mo], 2'b00, mo}));
      else
        chk("R3 forced zero", int'({s_trans, s_burst, s_lock, s_master}), 0);
    end
    stick = mv && lk[mo] && (rq[mo] || mhold);
    if (!rdy) why = "R2";
    else begin
      mhold = stick;
      if (stick) why = "R8";
      else if (rq != 0) begin
        for (int k = 0; k < N; k++) begin
          if (rq[(int'(mptr) + k) % N] && why != "R1x") begin
            mo = 2'((int'(mptr) + k) % N);
            why = "R1x";
          end
        end
        why = "R1"; mv = 1; mptr = 2'((int'(mo) + 1) % N);
      end else if (park_mode == 2'b00) begin
        why = "R4"; mo = park_id; mv = 1;
      end else if (park_mode == 2'b01) why = "R5";
      else begin why = "R6"; mv = 0; end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; park_mode = 2'b00; park_id = 2'd2; s_ready = 1;
    m_req = 0; m_lock = 0; m_trans = 0; m_burst = 0; m_addr = 0; m_write = 0;
    mo = 0; mv = 0; mptr = 0; mhold = 0; why = "R9";
    #11;
    @(negedge clk);
    chk("R9 reset owner_vld", int'(owner_vld), 0);
    chk("R9 reset owner_idx", int'(owner_idx), 0);
    rst_n = 1;
    // fixed park on 2, then owner and non-owner requests
    step(4'b0000, 4'b0000, 1);
    step(4'b0100, 4'b0000, 1);
    step(4'b0010, 4'b0000, 1);
    step(4'b0010, 4'b0000, 1);
    // full contention with ready gaps
    for (int j = 0; j < 12; j++) step(4'b1111, 4'b0000, (j % 3) != 2);
    // lock hold against other requests and low-power parking
    park_mode = 2'b10;
    step(4'b0001, 4'b0001, 1);
    step(4'b0001, 4'b0001, 1);
    step(4'b1110, 4'b0001, 1);
    step(4'b0000, 4'b0001, 1);
    step(4'b0000, 4'b0000, 1);
    step(4'b0000, 4'b0000, 1);
    step(4'b1000, 4'b0000, 1);
    step(4'b1000, 4'b0000, 1);
    // sweeps over every mode and park index
    for (int md = 0; md < 4; md++) begin
      for (int pid = 0; pid < N; pid++) begin
        park_mode = 2'(md); park_id = 2'(pid);
        for (int t = 0; t < 150; t++) begin
          logic [N-1:0] rq, lk;
          rq = ((t % 10) < 3) ? 4'b0000 : 4'($urandom);
          lk = 4'($urandom) & 4'($urandom) & 4'($urandom);
          step(rq, lk, ($urandom % 4) != 0);
        end
      end
    end
    finish_run();
  end

endmodule